// File: doc/BRIEF.md
# String Load Byte Packing Sequencer

This block performs a multi-register string load. A single start pulse captures a base operand, an index operand, the register numbers that name them, a destination register number and a 7-bit byte count. The sequencer then fetches the bytes one at a time over a byte-wide memory request port with a valid/ready handshake. It packs them big-endian into 32-bit words and writes each finished word to a 32-entry register file through an index/data write port.

Destination register numbers advance by one per word and wrap from 31 to 0. The last word is padded with zeros below its final byte. At the start pulse the block also decides whether the operand combination is an invalid form: a source register that would be overwritten by the load, or a zero base field together with a zero destination field. It reports the result on a level output. The load still runs either way, and the caller decides what to do with the flag.

Top module: `strload_seq`

## Requirements
- R1: The first memory address is `indexVal + baseVal`, except that a `baseRegNum` of 0 selects a base of zero and `baseVal` is ignored.
- R2: Memory addresses rise by one per accepted byte. A request holds its address while `memReady` is low, exactly one byte is consumed per cycle with `memValid` and `memReady` both high, and `memValid` stays low while the block is idle.
- R3: Within a written word, the byte from the lowest address lands in bits 31:24, the next in 23:16, then 15:8, then 7:0.
- R4: ceil(byteCount/4) writes are issued. The first goes to `destRegNum` and each later one to the previous index plus one, taken modulo 32 (31 is followed by 0).
- R5: In the last word, every byte lane after the final loaded byte reads as zero.
- R6: `rfWe` pulses for one cycle exactly one cycle after the handshake that delivers the fourth byte of a word or the last byte of the count. `rfIdx` and `rfData` are valid in that cycle.
- R7: With a byte count of 0 there are no memory requests and no writes, and `done` is high in the cycle after the start is accepted.
- R8: `done` is a one-cycle pulse in the cycle right after the final register write.
- R9: From the cycle after an accepted start until the next accepted start, `invalidForm` is 1 exactly when at least one of these holds: a nonzero `baseRegNum` lies in the set of registers to be written; `indexRegNum` lies in that set; `baseRegNum` and `destRegNum` are both 0. It reads 0 after reset.
- R10: A start while `busy` is high is ignored. Operands are not captured, the running load is not disturbed, and `invalidForm` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse; operands are captured when idle |
| baseRegNum | input | 5 | Base register number; 0 selects a zero base |
| indexRegNum | input | 5 | Index register number |
| destRegNum | input | 5 | First destination register |
| baseVal | input | 32 | Base operand value |
| indexVal | input | 32 | Index operand value |
| byteCount | input | 7 | Number of bytes to load |
| memValid | output | 1 | Byte request valid |
| memAddr | output | 32 | Byte request address |
| memReady | input | 1 | Memory accepts request; `memData` valid |
| memData | input | 8 | Returned byte |
| rfWe | output | 1 | Register write strobe |
| rfIdx | output | 5 | Register write index |
| rfData | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| invalidForm | output | 1 | Invalid operand combination of last accepted start |

## Verification
Two events can fall in the same cycle. One is the register write of a word completed by the previous handshake. The other is the acceptance of the first byte of the next word. Holding `memReady` high provokes this overlap on every word boundary, and a pseudo-random `memReady` pattern separates the two events. In both cases the per-clock reference model judges them independently: it checks the write pulse against the handshake that completed the word, and it checks the address against its expected byte stream.

// File: rtl/strload_pkg.sv
package strload_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 7;
  localparam int RIDX_W = 5;

  typedef struct packed {
    logic load;  // capture operands
    logic take;  // byte accepted this cycle
    logic emit;  // accepted byte completes a word
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_LAST,
    ST_DONE
  } state_t;
endpackage

// File: rtl/strload_ctl.sv
module strload_ctl
  import strload_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    cntZero,
  input  logic    memReady,
  input  logic    lastByte,
  input  logic    laneFull,
  output strobe_t strb,
  output logic    memValid,
  output logic    busy,
  output logic    done
);
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        strb.load = startReq;
        if (startReq) stateD = cntZero ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        strb.take = memReady;
        strb.emit = memReady && (lastByte || laneFull);
        if (memReady && lastByte) stateD = ST_LAST;
      end
      ST_LAST: stateD = ST_DONE;
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memValid = (stateQ == ST_RUN);
  assign busy     = (stateQ != ST_IDLE);
  assign done     = (stateQ == ST_DONE);
endmodule

// File: rtl/strload_dp.sv
module strload_dp
  import strload_pkg::*;
#(
  parameter int XLEN  = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int CW    = CNT_W,
  parameter int RW    = RIDX_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [RW-1:0]   baseRegNum,
  input  logic [RW-1:0]   indexRegNum,
  input  logic [RW-1:0]   destRegNum,
  input  logic [AW-1:0]   baseVal,
  input  logic [AW-1:0]   indexVal,
  input  logic [CW-1:0]   byteCount,
  input  logic [7:0]      memData,
  output logic [AW-1:0]   memAddr,
  output logic            cntZero,
  output logic            lastByte,
  output logic            laneFull,
  output logic            rfWe,
  output logic [RW-1:0]   rfIdx,
  output logic [XLEN-1:0] rfData,
  output logic            invalidForm
);
  localparam int BPW    = XLEN / 8;
  localparam int LANE_W = $clog2(BPW);
  localparam int CW1    = CW + 1;

  logic [AW-1:0]     addrQ;
  logic [CW-1:0]     remQ;
  logic [LANE_W-1:0] laneQ;
  logic [XLEN-1:0]   wordQ;
  logic [RW-1:0]     regQ;
  logic              invQ;

  // Operand checks at start
  logic [CW1-1:0] regsNeeded;
  logic [RW-1:0]  baseOff, idxOff;
  logic           baseHit, idxHit, bothZero, invNext;
  logic [AW-1:0]  effAddr;

  always_comb begin
    regsNeeded = (CW1'(byteCount) + CW1'(BPW - 1)) >> LANE_W;
    baseOff    = baseRegNum - destRegNum;
    idxOff     = indexRegNum - destRegNum;
    baseHit    = (baseRegNum != '0) && (CW1'(baseOff) < regsNeeded);
    idxHit     = CW1'(idxOff) < regsNeeded;
    bothZero   = (baseRegNum == '0) && (destRegNum == '0);
    invNext    = baseHit || idxHit || bothZero;
    effAddr    = indexVal + ((baseRegNum == '0) ? '0 : baseVal);
  end

  // Byte placement: lane 0 is the most significant byte
  logic [XLEN-1:0] packed_w;
  always_comb begin
    packed_w = wordQ | (XLEN'(memData) << {~laneQ, 3'b000});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      remQ   <= '0;
      laneQ  <= '0;
      wordQ  <= '0;
      regQ   <= '0;
      invQ   <= 1'b0;
      rfWe   <= 1'b0;
      rfIdx  <= '0;
      rfData <= '0;
    end else begin
      rfWe <= 1'b0;
      if (strb.load) begin
        addrQ <= effAddr;
        remQ  <= byteCount;
        laneQ <= '0;
        wordQ <= '0;
        regQ  <= destRegNum;
        invQ  <= invNext;
      end else if (strb.take) begin
        addrQ <= addrQ + 1'b1;
        remQ  <= remQ - 1'b1;
        if (strb.emit) begin
          rfWe   <= 1'b1;
          rfIdx  <= regQ;
          rfData <= packed_w;
          regQ   <= regQ + 1'b1;
          laneQ  <= '0;
          wordQ  <= '0;
        end else begin
          laneQ <= laneQ + 1'b1;
          wordQ <= packed_w;
        end
      end
    end
  end

  assign memAddr     = addrQ;
  assign cntZero     = (byteCount == '0);
  assign lastByte    = (remQ == CW'(1));
  assign laneFull    = &laneQ;
  assign invalidForm = invQ;
endmodule

// File: rtl/strload_seq.sv
module strload_seq
  import strload_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [4:0]  baseRegNum,
  input  logic [4:0]  indexRegNum,
  input  logic [4:0]  destRegNum,
  input  logic [31:0] baseVal,
  input  logic [31:0] indexVal,
  input  logic [6:0]  byteCount,
  output logic        memValid,
  output logic [31:0] memAddr,
  input  logic        memReady,
  input  logic [7:0]  memData,
  output logic        rfWe,
  output logic [4:0]  rfIdx,
  output logic [31:0] rfData,
  output logic        busy,
  output logic        done,
  output logic        invalidForm
);
  strobe_t strb;
  logic    cntZero, lastByte, laneFull;

  strload_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cntZero  (cntZero),
    .memReady (memReady),
    .lastByte (lastByte),
    .laneFull (laneFull),
    .strb     (strb),
    .memValid (memValid),
    .busy     (busy),
    .done     (done)
  );

  strload_dp #(
    .XLEN (32),
    .AW   (32),
    .CW   (7),
    .RW   (5)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .baseRegNum  (baseRegNum),
    .indexRegNum (indexRegNum),
    .destRegNum  (destRegNum),
    .baseVal     (baseVal),
    .indexVal    (indexVal),
    .byteCount   (byteCount),
    .memData     (memData),
    .memAddr     (memAddr),
    .cntZero     (cntZero),
    .lastByte    (lastByte),
    .laneFull    (laneFull),
    .rfWe        (rfWe),
    .rfIdx       (rfIdx),
    .rfData      (rfData),
    .invalidForm (invalidForm)
  );
endmodule

// File: rtl/strload_chk.sv
module strload_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startReq,
  input logic [6:0]  byteCount,
  input logic        memValid,
  input logic [31:0] memAddr,
  input logic        memReady,
  input logic        rfWe,
  input logic [4:0]  rfIdx,
  input logic        busy,
  input logic        done,
  input logic        invalidForm
);
  logic [4:0] prevIdx;
  logic       seenWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIdx   <= '0;
      seenWrite <= 1'b0;
    end else if (done) begin
      seenWrite <= 1'b0;
    end else if (rfWe) begin
      prevIdx   <= rfIdx;
      seenWrite <= 1'b1;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady |=> !memValid || (memAddr == $past(memAddr) + 32'd1)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid && !rfWe); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rfWe && seenWrite |-> rfIdx == prevIdx + 5'd1); // R4
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !busy && (byteCount == 7'd0) |=> done && !rfWe && !memValid); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rfWe && !memValid |=> done); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    busy && startReq |=> $stable(invalidForm)); // R10
endmodule

bind strload_seq strload_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .byteCount   (byteCount),
  .memValid    (memValid),
  .memAddr     (memAddr),
  .memReady    (memReady),
  .rfWe        (rfWe),
  .rfIdx       (rfIdx),
  .busy        (busy),
  .done        (done),
  .invalidForm (invalidForm)
);

// File: tb/sim_strload_seq.sv
`timescale 1ns/1ps
module sim_strload_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [4:0]  baseRegNum = '0, indexRegNum = '0, destRegNum = '0;
  logic [31:0] baseVal = '0, indexVal = '0;
  logic [6:0]  byteCount = '0;
  logic        memValid, memReady = 1'b0;
  logic [31:0] memAddr;
  logic [7:0]  memData;
  logic        rfWe, busy, done, invalidForm;
  logic [4:0]  rfIdx;
  logic [31:0] rfData;

  always #2 clk = ~clk; // 250 MHz

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign memData = memByte(memAddr);

  strload_seq u0 (.*);

  int nChecks = 0, nFail = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Ready generation
  int readyMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady = (readyMode == 0) ? 1'b1 : lfsr[0];
  end

  // Reference model
  logic [31:0] expAddrQ[$];
  logic [36:0] expWrQ[$];
  bit expInv = 0, prevWe = 0, prevLast = 0, prevZero = 0, expWeNext = 0;
  int takenCnt = 0, runCnt = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      cycles++;
      if (memValid) begin
        chk(expAddrQ.size() > 0, "R2", "unexpected request", memAddr, 0);
        if (expAddrQ.size() > 0)
          chk(memAddr == expAddrQ[0], "R1 R2", "address", memAddr, expAddrQ[0]);
      end
      chk(rfWe == expWeNext, "R6", "write pulse timing", rfWe, expWeNext);
      chk(done == ((prevWe && prevLast) || prevZero), "R7 R8", "done timing",
          done, (prevWe && prevLast) || prevZero);
      chk(invalidForm == expInv, "R9", "invalid form", invalidForm, expInv);
      prevLast = 0;
      if (rfWe) begin
        chk(expWrQ.size() > 0, "R4", "extra write", rfIdx, 0);
        if (expWrQ.size() > 0) begin
          chk(rfIdx == expWrQ[0][36:32], "R4", "write index", rfIdx, expWrQ[0][36:32]);
          chk(rfData == expWrQ[0][31:0], "R3 R5", "write data", rfData, expWrQ[0][31:0]);
          void'(expWrQ.pop_front());
        end
        prevLast = (expWrQ.size() == 0);
      end
      if (done)
        chk(expAddrQ.size() == 0 && expWrQ.size() == 0, "R4 R7", "leftover work",
            expWrQ.size(), 0);
      expWeNext = 0;
      if (memValid && memReady && expAddrQ.size() > 0) begin
        void'(expAddrQ.pop_front());
        expWeNext = (takenCnt % 4 == 3) || (takenCnt == runCnt - 1);
        takenCnt++;
      end
      prevWe = rfWe;
      prevZero = 0;
      if (startReq && !busy) begin
        logic [31:0] ea, w;
        int nRegs;
        ea = indexVal + ((baseRegNum == 0) ? 32'd0 : baseVal);
        nRegs = (byteCount + 3) / 4;
        for (int k = 0; k < byteCount; k++) expAddrQ.push_back(ea + k);
        for (int r = 0; r < nRegs; r++) begin
          w = 0;
          for (int b = 0; b < 4; b++)
            if (r * 4 + b < byteCount)
              w[31 - 8*b -: 8] = memByte(ea + r * 4 + b);
          expWrQ.push_back({5'((destRegNum + r) % 32), w});
        end
        expInv = 0;
        if (baseRegNum != 0 && ((baseRegNum - destRegNum) & 5'h1f) < nRegs) expInv = 1;
        if (((indexRegNum - destRegNum) & 5'h1f) < nRegs) expInv = 1;
        if (baseRegNum == 0 && destRegNum == 0) expInv = 1;
        prevZero = (byteCount == 0);
        takenCnt = 0;
        runCnt = byteCount;
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 100000 && !finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic waitDone();
    int t = 0;
    do begin @(negedge clk); t++; end while (!done && t < 2000);
    chk(done, "R8", "done seen", done, 1);
  endtask

  task automatic launch(input logic [4:0] br, ir, dr, input logic [31:0] bv, iv,
                        input logic [6:0] cnt);
    @(posedge clk); #1;
    baseRegNum = br; indexRegNum = ir; destRegNum = dr;
    baseVal = bv; indexVal = iv; byteCount = cnt; startReq = 1;
    @(posedge clk); #1;
    startReq = 0;
  endtask

  task automatic runLoad(input logic [4:0] br, ir, dr, input logic [31:0] bv, iv,
                         input logic [6:0] cnt);
    launch(br, ir, dr, bv, iv, cnt);
    waitDone();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(!busy && !memValid && !rfWe && !done && !invalidForm, "R9", "reset state",
        {busy, memValid, rfWe, done, invalidForm}, 0);
    readyMode = 0;
    runLoad(5'd2, 5'd9, 5'd3, 32'h0000_1000, 32'h20, 7'd8);        // R3 full words
    runLoad(5'd0, 5'd5, 5'd30, 32'hDEAD_BEEF, 32'h0000_4402, 7'd10); // R1 R4 R5 wrap
    runLoad(5'd1, 5'd2, 5'd7, 32'h10, 32'h3, 7'd0);                // R7 zero count
    runLoad(5'd8, 5'd9, 5'd10, 32'h100, 32'h1, 7'd1);              // R5 single byte
    runLoad(5'd1, 5'd5, 5'd4, 32'h200, 32'h7, 7'd12);              // R9 index inside
    runLoad(5'd0, 5'd9, 5'd0, 32'h0, 32'h50, 7'd3);                // R9 both zero
    runLoad(5'd0, 5'd0, 5'd31, 32'h0, 32'hFFFF_FFFE, 7'd8);        // R9 wrap overlap
    readyMode = 1;
    runLoad(5'd3, 5'd4, 5'd12, 32'h8000, 32'h11, 7'd13);           // R2 R6 stalls
    runLoad(5'd1, 5'd2, 5'd0, 32'h9000, 32'h0, 7'd127);            // R4 R9 all regs
    // R10: start while busy is ignored
    launch(5'd6, 5'd7, 5'd20, 32'h600, 32'h4, 7'd9);
    repeat (3) @(posedge clk);
    #1 baseRegNum = 0; destRegNum = 0; byteCount = 0; startReq = 1;
    @(posedge clk); #1 startReq = 0;
    waitDone();
    repeat (3) @(negedge clk);
    chk(!busy && invalidForm == 0, "R10", "state after ignored start", invalidForm, 0);
    summary();
  end
endmodule